// File: doc/BRIEF.md
# LIFO Register Stack with Full and Empty Flags

This block is a last-in, first-out stack of 64 words kept in a register file. It uses a 6-bit top pointer that wraps modulo 64. A push first advances the pointer and then stores the incoming word at the new pointer value. A pop first returns the word at the current pointer and then moves the pointer back by one. As a result, the first stored word sits at address 1, and the 64th word sits at address 0.

The full and empty indications are not taken from an occupancy count. They come from checking the wrapped pointer after each accepted operation. A small controller with three named states tracks them:

- `ST_EMPTY` (empty flag high)
- `ST_PARTIAL` (neither flag high)
- `ST_FULL` (full flag high)

The transitions between these states are:

- `ST_EMPTY` to `ST_PARTIAL` on any accepted push.
- `ST_PARTIAL` to `ST_FULL` on a push that leaves the pointer at 0.
- `ST_PARTIAL` to `ST_EMPTY` on a pop that leaves the pointer at 0.
- `ST_FULL` to `ST_PARTIAL` on any accepted pop.
- Every other state and request pair holds the state.

Three kinds of request would corrupt the stack: a push while full, a pop while empty, and a push and pop in the same cycle. The block refuses all three, leaves its state unchanged, and raises a one-cycle error pulse. A host drives `push_req` or `pop_req` for one cycle per operation. Popped data appears on `pop_data` in the following cycle, qualified by `pop_valid`.

Top module: `lifo_regstack`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `top_ptr` is 0, `stk_empty` is 1, and `stk_full`, `op_error`, `pop_valid` and `pop_data` are 0.
- R2: An accepted push increments `top_ptr` by one modulo 64 and writes `push_data` into the word at the new pointer value, so the first word pushed onto an empty stack lands at address 1. It also clears `stk_empty`.
- R3: An accepted pop places the word at the current `top_ptr` on `pop_data` and raises `pop_valid` for exactly the next cycle. It then decrements `top_ptr` modulo 64 (0 becomes 63) and clears `stk_full`.
- R4: `stk_full` rises only after a push that leaves `top_ptr` at 0, which is the 64th push from empty.
- R5: `stk_empty` rises only after a pop that leaves `top_ptr` at 0, which is the pop of the word at address 1.
- R6: A push while `stk_full` is 1 changes neither `top_ptr`, the flags, nor any stored word, and `op_error` is 1 for the following cycle only.
- R7: A pop while `stk_empty` is 1 changes no state, does not raise `pop_valid`, and leaves `pop_data` at its last value, while `op_error` pulses for one cycle.
- R8: A push and a pop requested in the same cycle are both refused: state is unchanged and `op_error` pulses for one cycle.
- R9: Words come back in reverse order of pushing, including across the wrap, where the word at address 0 is the first one returned from a full stack.
- R10: `pop_data` holds the last popped word until the next accepted pop, and `stk_full` and `stk_empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Request to push `push_data` this cycle |
| pop_req | input | 1 | Request to pop the top word this cycle |
| push_data | input | 16 | Word to store on a push |
| pop_data | output | 16 | Last popped word (registered) |
| pop_valid | output | 1 | High for one cycle after an accepted pop |
| top_ptr | output | 6 | Current stack pointer |
| stk_full | output | 1 | Stack holds 64 words |
| stk_empty | output | 1 | Stack holds no words |
| op_error | output | 1 | One-cycle pulse after a refused request |

## Verification
On every cycle, the assertions check the following:

- The pointer moves by exactly plus or minus one on accepted operations.
- The pointer stays put on refused ones, and each refusal yields exactly one error pulse.
- Both flags only ever coincide with a zero pointer, and they are never high together.
- A flag drops immediately after an operation of the opposite kind.

Only the bench's scenarios can show the data side: that words land at the addresses that give strict reverse-order return across the 63-to-0 wrap, and that `pop_data` holds its value through refused pops.

// File: rtl/lifo_regstack_pkg.sv
package lifo_regstack_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } stk_state_e;

endpackage

// File: rtl/lifo_regstack_ctrl.sv
module lifo_regstack_ctrl #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] wr_addr,
    output logic             wr_en,
    output logic [PTR_W-1:0] rd_addr,
    output logic             rd_en,
    output logic             full,
    output logic             empty,
    output logic             err_pulse,
    output logic             rd_valid
);
    import lifo_regstack_pkg::*;

    stk_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [PTR_W-1:0] ptr_inc, ptr_dec;
    logic             push_ok, pop_ok, refused;
    logic             err_q, valid_q;

    assign ptr_inc = ptr_q + PTR_W'(1);
    assign ptr_dec = ptr_q - PTR_W'(1);

    // Next state and pointer
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        refused = 1'b0;
        if (push_req && pop_req) begin
            refused = 1'b1;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (pop_req) begin
                        refused = 1'b1;
                    end else if (push_req) begin
                        push_ok = 1'b1;
                        ptr_d   = ptr_inc;
                        state_d = (ptr_inc == '0) ? ST_FULL : ST_PARTIAL;
                    end
                end
                ST_PARTIAL: begin
                    if (push_req) begin
                        push_ok = 1'b1;
                        ptr_d   = ptr_inc;
                        state_d = (ptr_inc == '0) ? ST_FULL : ST_PARTIAL;
                    end else if (pop_req) begin
                        pop_ok  = 1'b1;
                        ptr_d   = ptr_dec;
                        state_d = (ptr_dec == '0) ? ST_EMPTY : ST_PARTIAL;
                    end
                end
                ST_FULL: begin
                    if (push_req) begin
                        refused = 1'b1;
                    end else if (pop_req) begin
                        pop_ok  = 1'b1;
                        ptr_d   = ptr_dec;
                        state_d = (ptr_dec == '0) ? ST_EMPTY : ST_PARTIAL;
                    end
                end
                default: begin
                    state_d = ST_EMPTY;
                    ptr_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            ptr_q   <= '0;
            err_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            err_q   <= refused;
            valid_q <= pop_ok;
        end
    end

    // Outputs
    always_comb begin
        full      = 1'b0;
        empty     = 1'b0;
        unique case (state_q)
            ST_EMPTY:   empty = 1'b1;
            ST_PARTIAL: ;
            ST_FULL:    full  = 1'b1;
            default:    empty = 1'b1;
        endcase
        ptr       = ptr_q;
        wr_en     = push_ok;
        wr_addr   = ptr_inc;
        rd_en     = pop_ok;
        rd_addr   = ptr_q;
        err_pulse = err_q;
        rd_valid  = valid_q;
    end

endmodule

// File: rtl/lifo_regstack_store.sv
module lifo_regstack_store #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] words [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= words[rd_addr];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [PTR_W-1:0]  top_ptr,
    output logic              stk_full,
    output logic              stk_empty,
    output logic              op_error
);
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic             wr_en, rd_en;

    lifo_regstack_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .ptr       (top_ptr),
        .wr_addr   (wr_addr),
        .wr_en     (wr_en),
        .rd_addr   (rd_addr),
        .rd_en     (rd_en),
        .full      (stk_full),
        .empty     (stk_empty),
        .err_pulse (op_error),
        .rd_valid  (pop_valid)
    );

    lifo_regstack_store #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (push_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (pop_data)
    );

endmodule

// File: rtl/lifo_regstack_chk.sv
module lifo_regstack_chk #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_req,
    input logic             pop_req,
    input logic [PTR_W-1:0] top_ptr,
    input logic             stk_full,
    input logic             stk_empty,
    input logic             op_error,
    input logic             pop_valid
);
    logic bad_req, push_acc, pop_acc;
    assign bad_req  = (push_req && pop_req) || (push_req && stk_full) || (pop_req && stk_empty);
    assign push_acc = push_req && !pop_req && !stk_full;
    assign pop_acc  = pop_req && !push_req && !stk_empty;

    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_acc |=> (top_ptr == PTR_W'($past(top_ptr) + PTR_W'(1))) && !stk_empty);

    p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_acc |=> (top_ptr == PTR_W'($past(top_ptr) - PTR_W'(1))) && pop_valid && !stk_full);

    p_full_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> (top_ptr == '0));

    p_empty_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stk_empty |-> (top_ptr == '0));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && stk_full) |=> $stable(top_ptr) && stk_full && op_error);

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && stk_empty) |=> $stable(top_ptr) && stk_empty && op_error && !pop_valid);

    p_dual_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req) |=> $stable(top_ptr) && op_error && !pop_valid);

    p_error_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_error |-> $past(bad_req));

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_full && stk_empty));

endmodule

bind lifo_regstack lifo_regstack_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .top_ptr   (top_ptr),
    .stk_full  (stk_full),
    .stk_empty (stk_empty),
    .op_error  (op_error),
    .pop_valid (pop_valid)
);

// File: tb/lifo_regstack_bench.sv
`timescale 1ns/1ps
module lifo_regstack_bench;
    localparam int PTR_W  = 6;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << PTR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_req = 1'b0;
    logic              pop_req = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic [DATA_W-1:0] pop_data;
    logic              pop_valid;
    logic [PTR_W-1:0]  top_ptr;
    logic              stk_full, stk_empty, op_error;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    lifo_regstack #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_lifo_regstack (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .push_data(push_data), .pop_data(pop_data), .pop_valid(pop_valid),
        .top_ptr(top_ptr), .stk_full(stk_full), .stk_empty(stk_empty),
        .op_error(op_error)
    );

    typedef struct packed {
        logic              push;
        logic              pop;
        logic [DATA_W-1:0] din;
        logic [PTR_W-1:0]  sp;
        logic              full;
        logic              empty;
        logic              err;
        logic              valid;
        logic [DATA_W-1:0] pdata;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 16'h0000, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000}, // R7 pop on empty
        '{1'b1, 1'b0, 16'h00A1, 6'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
        '{1'b1, 1'b0, 16'h00B2, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
        '{1'b1, 1'b1, 16'h3333, 6'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000}, // R8
        '{1'b0, 1'b1, 16'h0000, 6'd1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00B2}, // R3
        '{1'b0, 1'b0, 16'h0000, 6'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00B2}, // R10 hold
        '{1'b1, 1'b0, 16'h00C3, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00B2}, // R2
        '{1'b0, 1'b1, 16'h0000, 6'd1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00C3}, // R9
        '{1'b0, 1'b1, 16'h0000, 6'd0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00A1}, // R5
        '{1'b0, 1'b1, 16'h0000, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h00A1}, // R7
        '{1'b0, 1'b0, 16'h0000, 6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h00A1}  // R7 pulse ends
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [PTR_W-1:0] sp, input logic full,
                             input logic empty, input logic err, input logic valid);
        check({tag, " top_ptr"},   32'(top_ptr),   32'(sp));
        check({tag, " stk_full"},  32'(stk_full),  32'(full));
        check({tag, " stk_empty"}, 32'(stk_empty), 32'(empty));
        check({tag, " op_error"},  32'(op_error),  32'(err));
        check({tag, " pop_valid"}, 32'(pop_valid), 32'(valid));
    endtask

    // drive at negedge, registers update at posedge, check at following negedge
    task automatic step(input logic psh, input logic pp, input logic [DATA_W-1:0] d);
        push_req  = psh;
        pop_req   = pp;
        push_data = d;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check_all("R1 in reset", '0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R1 pop_data", 32'(pop_data), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", '0, 1'b0, 1'b1, 1'b0, 1'b0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].push, VEC[i].pop, VEC[i].din);
            check_all($sformatf("vec%0d", i), VEC[i].sp, VEC[i].full, VEC[i].empty,
                      VEC[i].err, VEC[i].valid);
            check($sformatf("vec%0d pop_data", i), 32'(pop_data), 32'(VEC[i].pdata));
        end

        // fill from empty: R2 pointer advance, R4 full on 64th push
        for (int i = 1; i <= DEPTH; i++) begin
            step(1'b1, 1'b0, DATA_W'(16'h1000 + i));
            if (i < DEPTH)
                check_all($sformatf("R2 push %0d", i), PTR_W'(i), 1'b0, 1'b0, 1'b0, 1'b0);
            else
                check_all("R4 full at 64th push", '0, 1'b1, 1'b0, 1'b0, 1'b0);
        end

        // R6 push while full refused
        step(1'b1, 1'b0, 16'hDEAD);
        check_all("R6 push on full", '0, 1'b1, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, '0);
        check_all("R6 pulse one cycle", '0, 1'b1, 1'b0, 1'b0, 1'b0);

        // drain: R3 wrap 0->63, R9 reverse order, R5 empty at end
        for (int k = 1; k <= DEPTH; k++) begin
            step(1'b0, 1'b1, '0);
            check($sformatf("R9 pop %0d data", k), 32'(pop_data), 32'(16'h1000 + DEPTH + 1 - k));
            if (k < DEPTH)
                check_all($sformatf("R3 pop %0d", k), PTR_W'(DEPTH - k), 1'b0, 1'b0, 1'b0, 1'b1);
            else
                check_all("R5 empty at last pop", '0, 1'b0, 1'b1, 1'b0, 1'b1);
        end
        step(1'b0, 1'b0, '0);
        check("R10 pop_data holds", 32'(pop_data), 32'h1001);
        check("R3 valid one cycle", 32'(pop_valid), 32'h0);

        // R1 reset mid-operation
        step(1'b1, 1'b0, 16'h5A5A);
        step(1'b0, 1'b1, '0);
        push_req = 1'b0;
        pop_req  = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 mid reset", '0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R1 mid reset pop_data", 32'(pop_data), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after mid reset", '0, 1'b0, 1'b1, 1'b0, 1'b0);

        finish_run();
    end

endmodule